// File: doc/BRIEF.md
# Vector Destination Writeback Merge Unit

This block forms the value written back to a 512-bit vector destination register. It takes a result vector made of 32-bit lanes and the old contents of the destination, and builds the final register image from them. Inside the operation length, a lane gets the new result, keeps its old value or is cleared. The choice depends on the per-lane writemask and on the zeroing option. Bits above the operation length are kept or cleared according to the encoding class of the instruction.

The encoding that supports masking can also take one 32-bit element from lane 0 of the result input and copy it into every lane. A check on a reserved register-specifier field, together with a check on the encoding and length codes, raises an undefined-opcode fault and suppresses the write. The merged value, the write enable and the fault are all registered, and they appear one clock after the input is accepted.

Top module: `vwm_top`

## Requirements
- R1: With encoding code 2 (masked form) and masking in use, lane i inside the operation length takes result lane i when bit i of the writemask is 1 (lane i is bits 32*i+31 to 32*i).
- R2: With encoding code 2, masking in use and the zeroing input at 1, a lane inside the length whose mask bit is 0 is written as zero.
- R3: With encoding code 2, masking in use and the zeroing input at 0, a lane inside the length whose mask bit is 0 keeps its old value.
- R4: With encoding code 1 (plain vector form), every lane inside the length takes the result. Bits from the length up to bit 511 are cleared. The mask, zeroing and broadcast inputs have no effect.
- R5: With encoding code 0 (legacy form), the length is always 128 bits whatever the length code. Lanes 0 to 3 take the result and bits 511:128 keep their old value. Mask, zeroing and broadcast have no effect.
- R6: With encoding code 2, bits from the operation length up to bit 511 are cleared. Length codes: 0 means 128 bits, 1 means 256 bits, 2 means 512 bits.
- R7: With encoding code 2 and the broadcast input at 1, bits 31:0 of the result input act as the source for every lane.
- R8: With encoding code 2 and the no-mask input at 1, every lane inside the length is written, whatever the mask bits are.
- R9: A reserved field other than 4'b1111, encoding code 3 or length code 3 sets the fault output and leaves the write enable low. The output data keeps its previous value.
- R10: The outputs follow an accepted input by exactly one clock. A cycle with the valid input low gives a write enable of 0 and a fault of 0, and the data is held.
- R11: A synchronous active-high reset clears the write enable, the fault and the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| in_enc | input | 2 | Encoding class: 0 legacy, 1 plain vector, 2 masked, 3 illegal |
| in_vlen | input | 2 | Operation length: 0 128-bit, 1 256-bit, 2 512-bit, 3 illegal |
| in_mask | input | 16 | Per-lane writemask |
| in_mask_none | input | 1 | No-mask register selected; all lanes enabled |
| in_zero | input | 1 | Zeroing (1) or merging (0) for masked-off lanes |
| in_bcast | input | 1 | Replicate result lane 0 across lanes |
| in_rsvd | input | 4 | Reserved register-specifier field |
| in_result | input | 512 | Lane results |
| in_old | input | 512 | Old destination contents |
| out_we | output | 1 | Registered write enable |
| out_fault | output | 1 | Registered undefined-opcode fault |
| out_data | output | 512 | Registered merged destination value |

## Verification
Each lane of the output is either the new result, the old value or zero. A wrong lane select or a wrong length decode therefore shows up as a wrong 32-bit slice of `out_data` in the cycle right after the input. A reference model in the bench compares all 512 bits every clock, so such an error is caught within one cycle. A bad fault decode shows up at once as a wrong `out_fault` or `out_we`. If the data is not held on a fault or idle cycle, the bench sees it at the next compare.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_PLAIN  = 2'd1,
    ENC_MASKED = 2'd2,
    ENC_BAD    = 2'd3
  } enc_e;

  localparam logic [1:0] LEN_128 = 2'd0;
  localparam logic [1:0] LEN_256 = 2'd1;
  localparam logic [1:0] LEN_512 = 2'd2;
  localparam logic [1:0] LEN_BAD = 2'd3;

  localparam logic [3:0] RSVD_OK = 4'b1111;
endpackage

// File: rtl/vwm_decode.sv
module vwm_decode
  import vwm_pkg::*;
#(
  parameter int VREG_W = 512,
  parameter int LANE_W = 32
) (
  input  logic [1:0]                 enc,
  input  logic [1:0]                 vlen,
  input  logic [VREG_W/LANE_W-1:0]   mask,
  input  logic                       mask_none,
  input  logic                       zero_en,
  input  logic [3:0]                 rsvd,
  output logic                       fault,
  output logic [VREG_W/LANE_W-1:0]   sel_new,
  output logic [VREG_W/LANE_W-1:0]   sel_old
);
  localparam int NLANES = VREG_W / LANE_W;
  localparam int L128   = 128 / LANE_W;
  localparam int CW     = $clog2(NLANES + 1);

  logic [CW-1:0] n_act;
  logic          is_masked;
  logic          is_legacy;
  logic          use_mask;
  logic          zero_eff;

  assign is_masked = (enc == ENC_MASKED);
  assign is_legacy = (enc == ENC_LEGACY);
  assign use_mask  = is_masked & ~mask_none;
  assign zero_eff  = is_masked & zero_en;
  assign fault     = (rsvd != RSVD_OK) | (enc == ENC_BAD) | (vlen == LEN_BAD);

  always_comb begin
    if (is_legacy) begin
      n_act = CW'(L128);
    end else begin
      case (vlen)
        LEN_128: n_act = CW'(L128);
        LEN_256: n_act = CW'(2 * L128);
        LEN_512: n_act = CW'(NLANES);
        default: n_act = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NLANES; i++) begin : g_lane_sel
    logic in_len;
    logic lane_en;
    assign in_len     = (CW'(i) < n_act);
    assign lane_en    = ~use_mask | mask[i];
    assign sel_new[i] = in_len & lane_en;
    assign sel_old[i] = in_len ? (~lane_en & ~zero_eff) : is_legacy;
  end
endmodule

// File: rtl/vwm_lane.sv
module vwm_lane #(
  parameter int LANE_W = 32
) (
  input  logic              sel_new,
  input  logic              sel_old,
  input  logic [LANE_W-1:0] src,
  input  logic [LANE_W-1:0] old,
  output logic [LANE_W-1:0] lane
);
  always_comb begin
    if (sel_new)      lane = src;
    else if (sel_old) lane = old;
    else              lane = '0;
  end
endmodule

// File: rtl/vwm_top.sv
module vwm_top
  import vwm_pkg::*;
#(
  parameter int VREG_W = 512,
  parameter int LANE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [1:0]               in_enc,
  input  logic [1:0]               in_vlen,
  input  logic [VREG_W/LANE_W-1:0] in_mask,
  input  logic                     in_mask_none,
  input  logic                     in_zero,
  input  logic                     in_bcast,
  input  logic [3:0]               in_rsvd,
  input  logic [VREG_W-1:0]        in_result,
  input  logic [VREG_W-1:0]        in_old,
  output logic                     out_we,
  output logic                     out_fault,
  output logic [VREG_W-1:0]        out_data
);
  localparam int NLANES = VREG_W / LANE_W;

  logic              fault_c;
  logic [NLANES-1:0] sel_new;
  logic [NLANES-1:0] sel_old;
  logic              bcast_eff;
  logic [VREG_W-1:0] merged;

  vwm_decode #(.VREG_W(VREG_W), .LANE_W(LANE_W)) u_decode (
    .enc       (in_enc),
    .vlen      (in_vlen),
    .mask      (in_mask),
    .mask_none (in_mask_none),
    .zero_en   (in_zero),
    .rsvd      (in_rsvd),
    .fault     (fault_c),
    .sel_new   (sel_new),
    .sel_old   (sel_old)
  );

  assign bcast_eff = in_bcast & (in_enc == ENC_MASKED);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [LANE_W-1:0] src;
    assign src = bcast_eff ? in_result[LANE_W-1:0] : in_result[i*LANE_W +: LANE_W];
    vwm_lane #(.LANE_W(LANE_W)) u_lane (
      .sel_new (sel_new[i]),
      .sel_old (sel_old[i]),
      .src     (src),
      .old     (in_old[i*LANE_W +: LANE_W]),
      .lane    (merged[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_we    <= 1'b0;
      out_fault <= 1'b0;
      out_data  <= '0;
    end else begin
      out_we    <= in_valid & ~fault_c;
      out_fault <= in_valid & fault_c;
      if (in_valid & ~fault_c) out_data <= merged;
    end
  end

  // R9: fault and write enable are never high together
  assert_fault_no_we_R9: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> !out_we);

  // R9: bad reserved field gives a fault and keeps the data
  assert_rsvd_fault_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(in_valid) && ($past(in_rsvd) != RSVD_OK)
      |-> out_fault && $stable(out_data));

  // R5: legacy form keeps the upper bits of the old value
  assert_legacy_upper_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && out_we && ($past(in_enc) == ENC_LEGACY)
      |-> out_data[VREG_W-1:128] == $past(in_old[VREG_W-1:128]));

  // R4, R6: newer forms clear the bits above a 128-bit length
  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && out_we && ($past(in_enc) != ENC_LEGACY) && ($past(in_vlen) == LEN_128)
      |-> out_data[VREG_W-1:128] == '0);

  // R2: zeroing clears a masked-off lane 0
  assert_zero_lane0_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && out_we && ($past(in_enc) == ENC_MASKED) && $past(in_zero)
      && !$past(in_mask_none) && !$past(in_mask[0])
      |-> out_data[LANE_W-1:0] == '0);

  // R10: an idle cycle leaves the write enable low
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(in_valid) |-> !out_we && !out_fault && $stable(out_data));
endmodule

// File: tb/vwm_top_tb.sv
module vwm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;
  localparam int LW = 32;
  localparam int NL = VW / LW;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_enc = 2'd0;
  logic [1:0]    in_vlen = 2'd0;
  logic [NL-1:0] in_mask = '0;
  logic          in_mask_none = 1'b0;
  logic          in_zero = 1'b0;
  logic          in_bcast = 1'b0;
  logic [3:0]    in_rsvd = 4'hF;
  logic [VW-1:0] in_result = '0;
  logic [VW-1:0] in_old = '0;
  logic          out_we;
  logic          out_fault;
  logic [VW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic          exp_we = 1'b0;
  logic          exp_fault = 1'b0;
  logic [VW-1:0] exp_data = '0;
  string         cur_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  vwm_top #(.VREG_W(VW), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_enc(in_enc), .in_vlen(in_vlen),
    .in_mask(in_mask), .in_mask_none(in_mask_none), .in_zero(in_zero),
    .in_bcast(in_bcast), .in_rsvd(in_rsvd), .in_result(in_result), .in_old(in_old),
    .out_we(out_we), .out_fault(out_fault), .out_data(out_data)
  );

  function automatic logic [VW-1:0] ref_merge(
    input logic [1:0] enc, input logic [1:0] vlen, input logic [NL-1:0] mask,
    input logic mnone, input logic zero, input logic bcast,
    input logic [VW-1:0] res, input logic [VW-1:0] old);
    logic [VW-1:0] r;
    int nact;
    r = '0;
    nact = (enc == 2'd0) ? 4 : (4 << vlen);
    for (int i = 0; i < NL; i++) begin
      logic [LW-1:0] s;
      logic en;
      s = (enc == 2'd2 && bcast) ? res[LW-1:0] : res[i*LW +: LW];
      if (i < nact) begin
        en = (enc != 2'd2) || mnone || mask[i];
        if (en) r[i*LW +: LW] = s;
        else if (enc == 2'd2 && zero) r[i*LW +: LW] = '0;
        else r[i*LW +: LW] = old[i*LW +: LW];
      end else begin
        r[i*LW +: LW] = (enc == 2'd0) ? old[i*LW +: LW] : '0;
      end
    end
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (out_we !== exp_we || out_fault !== exp_fault) begin
      errors++;
      $display("FAIL %s we/fault actual %b/%b expected %b/%b", cur_tag,
               out_we, out_fault, exp_we, exp_fault);
    end
    checks++;
    if (out_data !== exp_data) begin
      errors++;
      $display("FAIL %s data actual %h expected %h", cur_tag, out_data, exp_data);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] enc, input logic [1:0] vlen,
                       input logic [NL-1:0] mask, input logic mnone, input logic zero,
                       input logic bcast, input logic [3:0] rsvd, input string tag);
    logic bad;
    @(negedge clk);
    compare();
    in_valid = v; in_enc = enc; in_vlen = vlen; in_mask = mask;
    in_mask_none = mnone; in_zero = zero; in_bcast = bcast; in_rsvd = rsvd;
    for (int i = 0; i < NL; i++) begin
      in_result[i*LW +: LW] = $urandom;
      in_old[i*LW +: LW]    = $urandom;
    end
    bad = (rsvd != 4'hF) || (enc == 2'd3) || (vlen == 2'd3);
    exp_we    = v && !bad;
    exp_fault = v && bad;
    if (v && !bad)
      exp_data = ref_merge(enc, vlen, mask, mnone, zero, bcast, in_result, in_old);
    cur_tag = tag;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R11: reset state
    rst = 1'b1;
    in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst = 1'b0;
    in_valid = 1'b0;
    cur_tag = "R11";
    // R1, R3: masked merge at 512 bits
    drive(1, 2'd2, 2'd2, 16'hA5A5, 0, 0, 0, 4'hF, "R1");
    drive(1, 2'd2, 2'd2, 16'h3C0F, 0, 0, 0, 4'hF, "R3");
    // R2: zeroing
    drive(1, 2'd2, 2'd2, 16'hA5A5, 0, 1, 0, 4'hF, "R2");
    drive(1, 2'd2, 2'd1, 16'h00F0, 0, 1, 0, 4'hF, "R2");
    // R4: plain vector 128 and 256, mask ignored
    drive(1, 2'd1, 2'd0, 16'h0000, 0, 1, 1, 4'hF, "R4");
    drive(1, 2'd1, 2'd1, 16'h0000, 0, 1, 1, 4'hF, "R4");
    drive(1, 2'd1, 2'd2, 16'h0001, 0, 0, 0, 4'hF, "R4");
    // R5: legacy keeps upper, length forced to 128
    drive(1, 2'd0, 2'd2, 16'h0000, 0, 1, 1, 4'hF, "R5");
    drive(1, 2'd0, 2'd0, 16'h0005, 0, 0, 0, 4'hF, "R5");
    // R6: masked form clears above length
    drive(1, 2'd2, 2'd1, 16'hFFFF, 0, 0, 0, 4'hF, "R6");
    drive(1, 2'd2, 2'd0, 16'hFFFF, 0, 0, 0, 4'hF, "R6");
    // R7: broadcast
    drive(1, 2'd2, 2'd2, 16'hFFFF, 0, 0, 1, 4'hF, "R7");
    drive(1, 2'd2, 2'd1, 16'h5555, 0, 1, 1, 4'hF, "R7");
    // R8: no mask register
    drive(1, 2'd2, 2'd2, 16'h0000, 1, 1, 0, 4'hF, "R8");
    // R9: faults keep data
    drive(1, 2'd2, 2'd2, 16'hFFFF, 0, 0, 0, 4'hE, "R9");
    drive(1, 2'd1, 2'd0, 16'hFFFF, 0, 0, 0, 4'h0, "R9");
    drive(1, 2'd3, 2'd0, 16'hFFFF, 0, 0, 0, 4'hF, "R9");
    drive(1, 2'd2, 2'd3, 16'hFFFF, 0, 0, 0, 4'hF, "R9");
    // R10: idle cycles and back-to-back
    drive(0, 2'd2, 2'd2, 16'hFFFF, 0, 0, 0, 4'hF, "R10");
    drive(0, 2'd1, 2'd0, 16'h0000, 0, 0, 0, 4'hF, "R10");
    for (int k = 0; k < 400; k++) begin
      logic [3:0] rs;
      rs = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      drive(1'($urandom % 4 != 0), 2'($urandom), 2'($urandom), NL'($urandom),
            1'($urandom % 4 == 0), 1'($urandom), 1'($urandom), rs, "R10");
    end
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule